// File: doc/BRIEF.md
# Serial Frequency-Synthesizer Programming Master

This controller reprograms an external frequency synthesizer whose output runs at the input frequency times M divided by D. A caller presents a new M and D pair with a single-cycle request. The controller checks both values against the legal ranges. If both are legal, it sends three serial commands in a fixed order: load the divisor, load the multiplier, then start. Each command is framed by an enable line, carried on a data line and clocked by a programming clock that the controller generates from its own clock. Enable is held low for a set number of programming-clock periods between commands.

After the start command the controller watches the synthesizer's done line. It reports success with a one-cycle ready pulse. If done never arrives, it reports failure with a one-cycle timeout pulse. Values are sent as the setting minus one, so each field fits in 8 bits. A request with an illegal value sends nothing and only pulses a range-error flag. A request that arrives while a transaction is running is dropped.

The controller steps through five states. It sits in IDLE until a legal request arrives. It then moves IDLE→LOAD, where it places the next command frame in the shifter. LOAD→SEND shifts the frame out. When a load command finishes, SEND→GAP holds enable low between commands. When the gap ends, GAP→LOAD prepares the next command. When the start command finishes, SEND→WAIT begins the wait for done. WAIT→IDLE happens either on done or when the timeout expires.

Top module: `fsynth_prog_master`

## Requirements
- R1: A request is taken only in IDLE. If M is outside 2..256 or D is outside 1..256, err_range pulses for one cycle in the cycle after the request, busy stays low and no frame is sent.
- R2: A legal request sends exactly three frames in this order: load-D, load-M, go.
- R3: A load frame is 10 bits long: a 2-bit opcode followed by the 8-bit value minus one. Both fields are sent LSB first. The opcodes are 01 for load-D and 11 for load-M. The go frame is the opcode 00 alone, 2 bits long.
- R4: The synthesizer samples one bit on each rising edge of prog_clk while prog_en is high. prog_data holds steady for the whole programming-clock period. prog_clk and prog_en stay low whenever the controller is not busy.
- R5: Between consecutive frames, prog_en stays low for exactly GAP_CYC rising edges of prog_clk. No prog_clk edge occurs after the go frame.
- R6: After the go frame, the first cycle in which prog_done is high is followed in the next cycle by a one-cycle ready pulse, and busy drops at the same time.
- R7: If prog_done stays low, err_timeout pulses for one cycle exactly TIMEOUT_CYC clock cycles after prog_en drops at the end of the go frame. The controller then returns to IDLE.
- R8: A request that arrives while busy is high is ignored. The frames in progress are not changed and no extra frames follow.
- R9: After reset, busy, ready, err_range, err_timeout, prog_clk, prog_en and prog_data are all low. At most one of ready, err_timeout and err_range is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_m | input | VAL_W+1 | Requested multiplier M |
| req_d | input | VAL_W+1 | Requested divisor D |
| busy | output | 1 | High while a transaction is running |
| ready | output | 1 | One-cycle pulse: new setting confirmed |
| err_range | output | 1 | One-cycle pulse: request rejected because a value is out of range |
| err_timeout | output | 1 | One-cycle pulse: done not seen in time |
| prog_clk | output | 1 | Programming clock, half the controller clock rate |
| prog_en | output | 1 | Command frame enable |
| prog_data | output | 1 | Serial command and data bit |
| prog_done | input | 1 | Completion indication from the synthesizer |

## Verification
The bench builds the controller with GAP_CYC set to 3 and TIMEOUT_CYC set to 100. The non-default gap shows whether the gap length follows the parameter rather than a hard-wired two periods. The short timeout lets the timeout path, and its exact cycle count, be reached within a short run. The default 8-bit field width is kept, so the range limits of 2 and 256 for M and 1 and 256 for D are tested exactly at their edges. The same default width lets random requests cover the whole legal range, with random delays before done.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND,
        ST_GAP,
        ST_WAIT
    } fsp_state_e;

    typedef enum logic [1:0] {
        CMD_LD_D,
        CMD_LD_M,
        CMD_GO
    } fsp_cmd_e;

    localparam int OPC_W = 2;
    localparam logic [OPC_W-1:0] OPC_LD_D = 2'b01;
    localparam logic [OPC_W-1:0] OPC_LD_M = 2'b11;
    localparam logic [OPC_W-1:0] OPC_GO   = 2'b00;

endpackage

// File: rtl/fsp_range_check.sv
module fsp_range_check #(
    parameter int VAL_W = 8
) (
    input  logic [VAL_W:0] m_val,
    input  logic [VAL_W:0] d_val,
    output logic           legal
);
    localparam logic [VAL_W:0] MAX_V = (VAL_W+1)'(1) << VAL_W;
    localparam logic [VAL_W:0] M_MIN = (VAL_W+1)'(2);
    localparam logic [VAL_W:0] D_MIN = (VAL_W+1)'(1);

    always_comb begin
        legal = (m_val >= M_MIN) && (m_val <= MAX_V) &&
                (d_val >= D_MIN) && (d_val <= MAX_V);
    end
endmodule

// File: rtl/fsp_frame_builder.sv
module fsp_frame_builder
    import fsp_pkg::*;
#(
    parameter int VAL_W = 8,
    localparam int FRM_W = OPC_W + VAL_W,
    localparam int LEN_W = $clog2(FRM_W + 1)
) (
    input  fsp_cmd_e         cmd,
    input  logic [VAL_W-1:0] d_m1,
    input  logic [VAL_W-1:0] m_m1,
    output logic [FRM_W-1:0] frame,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        unique case (cmd)
            CMD_LD_D: begin
                frame = {d_m1, OPC_LD_D};
                len   = LEN_W'(FRM_W);
            end
            CMD_LD_M: begin
                frame = {m_m1, OPC_LD_M};
                len   = LEN_W'(FRM_W);
            end
            default: begin
                frame = {{VAL_W{1'b0}}, OPC_GO};
                len   = LEN_W'(OPC_W);
            end
        endcase
    end
endmodule

// File: rtl/fsp_wait_timer.sv
module fsp_wait_timer #(
    parameter int LIMIT = 1024,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TW'(LIMIT - 1));
endmodule

// File: rtl/fsynth_prog_master.sv
module fsynth_prog_master
    import fsp_pkg::*;
#(
    parameter int VAL_W       = 8,
    parameter int GAP_CYC     = 2,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [VAL_W:0] req_m,
    input  logic [VAL_W:0] req_d,
    output logic           busy,
    output logic           ready,
    output logic           err_range,
    output logic           err_timeout,
    output logic           prog_clk,
    output logic           prog_en,
    output logic           prog_data,
    input  logic           prog_done
);
    localparam int FRM_W = OPC_W + VAL_W;
    localparam int LEN_W = $clog2(FRM_W + 1);
    localparam int GW    = $clog2(GAP_CYC + 1);
    localparam int CNT_W = (LEN_W > GW) ? LEN_W : GW;

    fsp_state_e        state;
    fsp_cmd_e          cmd;
    logic [FRM_W-1:0]  shreg;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  bitcnt;
    logic              ph;
    logic [VAL_W-1:0]  d_m1, m_m1;
    logic              ready_q, err_range_q, err_to_q;

    logic              legal;
    logic [FRM_W-1:0]  frame;
    logic [LEN_W-1:0]  frame_len;
    logic              expired;
    logic [VAL_W:0]    d_dec, m_dec;

    assign d_dec = req_d - 1'b1;
    assign m_dec = req_m - 1'b1;

    fsp_range_check #(.VAL_W(VAL_W)) u_range (
        .m_val (req_m),
        .d_val (req_d),
        .legal (legal)
    );

    fsp_frame_builder #(.VAL_W(VAL_W)) u_frame (
        .cmd   (cmd),
        .d_m1  (d_m1),
        .m_m1  (m_m1),
        .frame (frame),
        .len   (frame_len)
    );

    fsp_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT),
        .expired (expired)
    );

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cmd         <= CMD_LD_D;
            shreg       <= '0;
            len_q       <= '0;
            bitcnt      <= '0;
            ph          <= 1'b0;
            d_m1        <= '0;
            m_m1        <= '0;
            ready_q     <= 1'b0;
            err_range_q <= 1'b0;
            err_to_q    <= 1'b0;
        end else begin
            ready_q     <= 1'b0;
            err_range_q <= 1'b0;
            err_to_q    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (legal) begin
                            d_m1  <= d_dec[VAL_W-1:0];
                            m_m1  <= m_dec[VAL_W-1:0];
                            cmd   <= CMD_LD_D;
                            state <= ST_LOAD;
                        end else begin
                            err_range_q <= 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    shreg  <= frame;
                    len_q  <= frame_len;
                    bitcnt <= '0;
                    ph     <= 1'b0;
                    state  <= ST_SEND;
                end
                ST_SEND: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (bitcnt == CNT_W'(len_q - 1'b1)) begin
                            bitcnt <= '0;
                            state  <= (cmd == CMD_GO) ? ST_WAIT : ST_GAP;
                        end else begin
                            shreg  <= shreg >> 1;
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (bitcnt == CNT_W'(GAP_CYC - 1)) begin
                            cmd   <= (cmd == CMD_LD_D) ? CMD_LD_M : CMD_GO;
                            state <= ST_LOAD;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (prog_done) begin
                        ready_q <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (expired) begin
                        err_to_q <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        prog_en     = (state == ST_SEND);
        prog_clk    = ((state == ST_SEND) || (state == ST_GAP)) && ph;
        prog_data   = (state == ST_SEND) && shreg[0];
        ready       = ready_q;
        err_range   = err_range_q;
        err_timeout = err_to_q;
    end
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic ready,
    input logic err_range,
    input logic err_timeout,
    input logic prog_clk,
    input logic prog_en,
    input logic prog_data,
    input logic prog_done
);
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!prog_en && !prog_clk));

    a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !prog_clk) |=> (prog_en && prog_clk && $stable(prog_data)));

    a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ($past(prog_done) && $past(busy) && !busy));

    a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> ($past(req_valid) && !$past(busy) && !busy));

    a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> ($past(busy) && !$past(prog_done) && !busy));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, err_timeout, err_range}));
endmodule

bind fsynth_prog_master fsp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .ready       (ready),
    .err_range   (err_range),
    .err_timeout (err_timeout),
    .prog_clk    (prog_clk),
    .prog_en     (prog_en),
    .prog_data   (prog_data),
    .prog_done   (prog_done)
);

// File: tb/sim_fsynth_prog_master.sv
`timescale 1ns/1ps
module sim_fsynth_prog_master;
    localparam int VAL_W = 8;
    localparam int GAP   = 3;
    localparam int TMO   = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VAL_W:0] req_m = '0, req_d = '0;
    logic busy, ready, err_range, err_timeout;
    logic prog_clk, prog_en, prog_data;
    logic prog_done = 1'b0;

    always #4 clk = ~clk;

    fsynth_prog_master #(.VAL_W(VAL_W), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_m(req_m), .req_d(req_d),
        .busy(busy), .ready(ready), .err_range(err_range), .err_timeout(err_timeout),
        .prog_clk(prog_clk), .prog_en(prog_en), .prog_data(prog_data), .prog_done(prog_done)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // monitor / responder state
    logic [9:0] fval [0:1023];
    int flen [0:1023];
    int fgap [0:1023];
    int nfr = 0;
    int done_delay = 0;
    int to_elapsed = -1;

    function automatic bit legal_req(input int m, input int d);
        return (m >= 2) && (m <= 256) && (d >= 1) && (d <= 256);
    endfunction

    function automatic logic [9:0] exp_frame(input int k, input int m, input int d);
        logic [7:0] v;
        if (k == 0) begin v = 8'(d - 1); return {v, 2'b01}; end
        if (k == 1) begin v = 8'(m - 1); return {v, 2'b11}; end
        return 10'b0;
    endfunction

    function automatic int exp_len(input int k);
        return (k == 2) ? 2 : 10;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                finish_run();
            end
        end
    end

    // Serial monitor and synthesizer responder
    initial begin
        logic pclk_prev, en_prev;
        logic [9:0] cur;
        int blen, gapcnt, dcnt, elapsed;
        bit armed, after_go;
        pclk_prev = 0; en_prev = 0; cur = '0;
        blen = 0; gapcnt = 0; dcnt = 0; elapsed = 0; armed = 0; after_go = 0;
        forever begin
            @(negedge clk);
            prog_done = 1'b0;
            if (after_go) elapsed++;
            if (err_timeout && after_go) begin
                to_elapsed = elapsed;
                after_go = 0;
            end
            if (ready) after_go = 0;
            if (!en_prev && prog_en) fgap[nfr] = gapcnt;
            if (prog_clk && !pclk_prev) begin
                if (prog_en) begin
                    if (blen < 10) cur[blen] = prog_data;
                    blen++;
                end else begin
                    gapcnt++;
                end
            end
            if (en_prev && !prog_en) begin
                fval[nfr] = cur;
                flen[nfr] = blen;
                if (blen == 2) begin
                    armed = (done_delay >= 0);
                    dcnt = done_delay;
                    after_go = 1;
                    elapsed = 0;
                end
                nfr++;
                cur = '0;
                blen = 0;
                gapcnt = 0;
            end
            if (armed) begin
                if (dcnt == 0) begin
                    prog_done = 1'b1;
                    armed = 0;
                end else begin
                    dcnt--;
                end
            end
            pclk_prev = prog_clk;
            en_prev = prog_en;
        end
    end

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // Issue one request and check everything the requirements say about it.
    // delay < 0: the responder never raises done. intrude: a second request
    // is pulsed while the transaction runs.
    task automatic run_req(input int m, input int d, input int delay, input bit intrude);
        int base, n;
        bit got_ready, got_to;
        base = nfr;
        done_delay = delay;
        to_elapsed = -1;
        req_m = (VAL_W+1)'(m);
        req_d = (VAL_W+1)'(d);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        if (!legal_req(m, d)) begin
            chk(err_range == 1'b1, "R1", "err_range pulse", err_range, 1);
            chk(busy == 1'b0, "R1", "busy after reject", busy, 0);
            tick();
            chk(err_range == 1'b0, "R1", "err_range one cycle", err_range, 0);
            repeat (40) tick();
            chk(nfr == base, "R1", "frames after reject", nfr - base, 0);
            return;
        end
        chk(busy == 1'b1 && err_range == 1'b0, "R9", "busy on accept", busy, 1);
        n = 0;
        got_ready = 0;
        got_to = 0;
        while (n < 3000) begin
            if (intrude && n == 12) begin
                req_m = 9'd100;
                req_d = 9'd50;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            tick();
            if (ready) begin got_ready = 1; break; end
            if (err_timeout) begin got_to = 1; break; end
            n++;
        end
        req_valid = 1'b0;
        #4;
        chk(nfr - base == 3, "R2", "frame count", nfr - base, 3);
        for (int k = 0; k < 3; k++) begin
            chk(flen[base+k] == exp_len(k), "R3", "frame length", flen[base+k], exp_len(k));
            chk(fval[base+k] == exp_frame(k, m, d), "R3", "frame bits",
                fval[base+k], exp_frame(k, m, d));
            if (k > 0)
                chk(fgap[base+k] == GAP, "R5", "gap edges", fgap[base+k], GAP);
        end
        if (delay >= 0) begin
            chk(got_ready, "R6", "ready seen", got_ready, 1);
            chk(busy == 1'b0, "R6", "idle with ready", busy, 0);
            tick();
            chk(ready == 1'b0, "R6", "ready one cycle", ready, 0);
        end else begin
            chk(got_to, "R7", "timeout seen", got_to, 1);
            chk(to_elapsed == TMO, "R7", "timeout cycles", to_elapsed, TMO);
            chk(busy == 1'b0, "R7", "idle after timeout", busy, 0);
            tick();
            chk(err_timeout == 1'b0, "R7", "timeout one cycle", err_timeout, 0);
        end
        if (intrude) begin
            repeat (60) tick();
            chk(nfr - base == 3, "R8", "no extra frames", nfr - base, 3);
            chk(busy == 1'b0, "R8", "stays idle", busy, 0);
        end
        chk(prog_en == 1'b0 && prog_clk == 1'b0, "R4", "lines quiet when idle",
            {prog_en, prog_clk}, 0);
        repeat (3) tick();
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) tick();
        chk(busy == 0 && ready == 0 && err_range == 0 && err_timeout == 0, "R9",
            "reset outcome flags", {busy, ready, err_range, err_timeout}, 0);
        chk(prog_clk == 0 && prog_en == 0 && prog_data == 0, "R9", "reset serial lines",
            {prog_clk, prog_en, prog_data}, 0);
        rst_n = 1'b1;
        repeat (2) tick();

        // directed corners
        run_req(14, 3, 0, 0);      // R3: D=3 -> 00000010, M=14 -> 00001101
        run_req(2, 1, 5, 0);       // lowest legal values
        run_req(256, 256, 1, 0);   // highest legal values
        run_req(1, 10, 0, 0);      // R1: M below range
        run_req(257, 10, 0, 0);    // R1: M above range
        run_req(20, 0, 0, 0);      // R1: D below range
        run_req(20, 257, 0, 0);    // R1: D above range
        run_req(77, 33, 4, 1);     // R8: request during busy
        run_req(9, 7, -1, 0);      // R7: no done
        run_req(150, 40, 2, 0);    // recovery after timeout

        // constrained random
        for (int i = 0; i < 20; i++) begin
            int m, d, dl;
            if (($urandom % 5) == 0) begin
                m = (($urandom % 2) == 0) ? int'($urandom % 2) : 257 + int'($urandom % 255);
                d = int'($urandom % 512);
            end else begin
                m = 2 + int'($urandom % 255);
                d = 1 + int'($urandom % 256);
            end
            dl = int'($urandom % 20);
            run_req(m, d, dl, 0);
        end
        finish_run();
    end
endmodule